// File: doc/BRIEF.md
# Card Initialization Stream Generator

Before the first command to a memory card, the host must run the card's bus clock for a fixed number of periods while holding the command line high, so that the card can finish its power-up. This block produces that sequence. When the init mode bit is set, an all-zero write to the command register does not start a real command. It starts a burst of card clock periods with the command line held high. When the burst is done, the block sends a one-cycle command-complete pulse to the status logic, which can record it.

The burst length is set by the parameter `PERIODS`, which defaults to 80. A period is counted only in a system clock cycle where the card clock enable is asserted. Because of this, the burst runs at whatever rate the clock divider supplies. With a card clock at or below 80 kHz, the default burst lasts at least about one millisecond. Software may start the stream twice in a row. Each run gives a full burst and its own completion pulse. When init mode is clear, command writes pass straight through to the normal command path. The card clock and command line then follow the normal path's signals.

Top module: `init_stream_gen`

## Requirements
- R1: With `init_mode` high and no stream running, a `cmd_wr` whose `cmd_wdata` is all zeros starts a stream. `busy` reads high from the next cycle.
- R2: A stream emits exactly `PERIODS` (80 by default) card clock periods. `card_clk_out` is high on exactly that many cycles while `busy` is high.
- R3: `cmd_line` is high in every cycle in which `busy` is high.
- R4: The cycle after the last period, `busy` falls and `cc_pulse` is high for exactly one cycle.
- R5: Cycles with `card_clk_en` low pause the stream. With an enable pattern of two high cycles then one low cycle, starting on the cycle after the write, `cc_pulse` appears 119 cycles after that first cycle.
- R6: With `init_mode` low, `cmd_wr` is forwarded on `norm_cmd_wr` in the same cycle, with `norm_cmd_data` equal to `cmd_wdata`. No stream starts.
- R7: Command writes that arrive while a stream is running are not forwarded and do not restart the count. The stream still emits exactly `PERIODS` periods.
- R8: A second start issued right after a completion runs a second full stream with its own `cc_pulse`.
- R9: With `init_mode` high, a write of a non-zero word starts no stream and is not forwarded.
- R10: While no stream is running, `card_clk_out` equals `norm_clk_en` and `cmd_line` equals `norm_cmd_line`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_mode | input | 1 | Init mode bit from the control register |
| cmd_wr | input | 1 | Command-register write strobe |
| cmd_wdata | input | DW | Command-register write data |
| card_clk_en | input | 1 | One card clock period is available this cycle |
| norm_clk_en | input | 1 | Card clock gating requested by the normal command path |
| norm_cmd_line | input | 1 | Command line level from the normal command path |
| card_clk_out | output | 1 | Card clock gating to the pad logic |
| cmd_line | output | 1 | Command line level to the card |
| cc_pulse | output | 1 | One-cycle command-complete event |
| busy | output | 1 | Stream in progress |
| norm_cmd_wr | output | 1 | Command write forwarded to the normal path |
| norm_cmd_data | output | DW | Forwarded command data |

## Verification
The assertions assume that `card_clk_en` is a level sampled once per system clock. They also assume that `init_mode` does not fall while a stream runs, since software clears it only after the completion. The bench holds `init_mode` high for every stream it starts. It drives the enable from fixed patterns, either always high or two high and one low, so the expected completion cycle can be computed in advance. It drives every input on the falling edge and samples one time unit later.

// File: rtl/init_stream_gen.sv
module init_stream_gen #(
  parameter int PERIODS = 80,
  parameter int DW      = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_mode,
  input  logic          cmd_wr,
  input  logic [DW-1:0] cmd_wdata,
  input  logic          card_clk_en,
  input  logic          norm_clk_en,
  input  logic          norm_cmd_line,
  output logic          card_clk_out,
  output logic          cmd_line,
  output logic          cc_pulse,
  output logic          busy,
  output logic          norm_cmd_wr,
  output logic [DW-1:0] norm_cmd_data
);
  localparam int CW = $clog2(PERIODS + 1);

  logic [CW-1:0] cnt;
  logic          run;
  logic          done;

  wire start = cmd_wr && init_mode && (cmd_wdata == '0) && !run;
  wire tick  = run && card_clk_en;
  wire last  = tick && (cnt == CW'(PERIODS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= last;
      if (start) begin
        run <= 1'b1;
        cnt <= '0;
      end else if (last) begin
        run <= 1'b0;
      end else if (tick) begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  assign busy          = run;
  assign cc_pulse      = done;
  assign card_clk_out  = run ? card_clk_en : norm_clk_en;
  assign cmd_line      = run | norm_cmd_line & ~run;
  assign norm_cmd_wr   = cmd_wr & ~init_mode;
  assign norm_cmd_data = cmd_wdata;

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> run && cnt == '0); // R1
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt < CW'(PERIODS)); // R2
  AST_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cmd_line); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cc_pulse |=> !cc_pulse); // R4
  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    cc_pulse |-> !run); // R4
  AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    run && !card_clk_en |=> run && $stable(cnt)); // R5
  AST_NO_FWD_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    init_mode |-> !norm_cmd_wr); // R6
  AST_IGNORE_WR: assert property (@(posedge clk) disable iff (!rst_n)
    run && cmd_wr && card_clk_en && cnt != CW'(PERIODS - 1) |=> cnt == $past(cnt) + CW'(1)); // R7
endmodule

// File: tb/init_stream_gen_tb.sv
module init_stream_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NPER = 80;

  logic clk = 1'b0, rst_n = 1'b0;
  logic init_mode = 1'b0, cmd_wr = 1'b0, card_clk_en = 1'b0;
  logic norm_clk_en = 1'b0, norm_cmd_line = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic card_clk_out, cmd_line, cc_pulse, busy, norm_cmd_wr;
  logic [31:0] norm_cmd_data;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  init_stream_gen u_dut (
    .clk(clk), .rst_n(rst_n), .init_mode(init_mode), .cmd_wr(cmd_wr),
    .cmd_wdata(cmd_wdata), .card_clk_en(card_clk_en), .norm_clk_en(norm_clk_en),
    .norm_cmd_line(norm_cmd_line), .card_clk_out(card_clk_out), .cmd_line(cmd_line),
    .cc_pulse(cc_pulse), .busy(busy), .norm_cmd_wr(norm_cmd_wr),
    .norm_cmd_data(norm_cmd_data));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(busy == 0, "reset busy", busy, 0);
    chk(cc_pulse == 0, "reset cc", cc_pulse, 0);
  endtask

  task automatic t_idle_pass();
    @(negedge clk);
    init_mode = 1'b1; norm_clk_en = 1'b1; norm_cmd_line = 1'b0; #1;
    chk(card_clk_out == 1 && cmd_line == 0, "R10 idle follows", {card_clk_out, cmd_line}, 2);
    @(negedge clk);
    norm_clk_en = 1'b0; norm_cmd_line = 1'b1; #1;
    chk(card_clk_out == 0 && cmd_line == 1, "R10 idle follows", {card_clk_out, cmd_line}, 1);
    norm_cmd_line = 1'b0;
  endtask

  task automatic t_forward();
    @(negedge clk);
    init_mode = 1'b0; cmd_wr = 1'b1; cmd_wdata = 32'h1234_5678; #1;
    chk(norm_cmd_wr == 1, "R6 forward strobe", norm_cmd_wr, 1);
    chk(norm_cmd_data == 32'h1234_5678, "R6 forward data", norm_cmd_data, 32'h1234_5678);
    @(negedge clk);
    cmd_wr = 1'b0; cmd_wdata = 32'h0; #1;
    chk(busy == 0, "R6 no stream", busy, 0);
  endtask

  task automatic t_nonzero();
    @(negedge clk);
    init_mode = 1'b1; cmd_wr = 1'b1; cmd_wdata = 32'h0000_0040; #1;
    chk(norm_cmd_wr == 0, "R9 not forwarded", norm_cmd_wr, 0);
    @(negedge clk);
    cmd_wr = 1'b0; cmd_wdata = '0; #1;
    chk(busy == 0, "R9 no stream", busy, 0);
  endtask

  // mode 0: enable always high; 1: two high one low; 2: stray writes during stream
  task automatic run_stream(input int mode, input string tag);
    int pulses = 0, line_bad = 0, fwd = 0, cc_at = -1;
    bit seen = 0;
    @(negedge clk);
    init_mode = 1'b1; cmd_wr = 1'b1; cmd_wdata = '0; card_clk_en = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 3000 && !seen; i++) begin
      card_clk_en = (mode == 1) ? (i % 3 != 2) : 1'b1;
      cmd_wr = (mode == 2 && i % 10 == 5);
      cmd_wdata = '0;
      #1;
      if (i == 0) chk(busy == 1, {"R1 busy after start ", tag}, busy, 1);
      if (busy && card_clk_out) pulses++;
      if (busy && !cmd_line) line_bad++;
      if (norm_cmd_wr) fwd++;
      if (cc_pulse) begin
        seen = 1; cc_at = i;
        chk(busy == 0, {"R4 busy low at cc ", tag}, busy, 0);
      end
      @(negedge clk);
    end
    cmd_wr = 1'b0; card_clk_en = 1'b1; #1;
    chk(seen, {"R4 cc seen ", tag}, seen, 1);
    chk(cc_pulse == 0, {"R4 cc one cycle ", tag}, cc_pulse, 0);
    chk(pulses == NPER, {"R2 period count ", tag}, pulses, NPER);
    chk(line_bad == 0, {"R3 line high ", tag}, line_bad, 0);
    if (mode == 1) chk(cc_at == 119, "R5 gapped completion cycle", cc_at, 119);
    else chk(cc_at == NPER, {"R4 completion cycle ", tag}, cc_at, NPER);
    if (mode == 2) chk(fwd == 0, "R7 stray writes dropped", fwd, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_idle_pass();
    t_forward();
    t_nonzero();
    run_stream(0, "basic");
    run_stream(1, "gapped");
    run_stream(2, "stray");
    run_stream(0, "R8 first");
    run_stream(0, "R8 second");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule